// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block models the device side of a small serial non-volatile memory. It runs from a system clock and synchronises the select (`cs_i`), shift clock (`sk_i`) and serial input (`di_i`) pins internally. It returns data on `do_o`, with `do_oe_o` acting as the tri-state enable. The storage is 1024 bits of flip-flops, seen as 128 bytes.

The `org_i` input picks the word size. When high, the array is 64 words of 16 bits. When low, it is 128 words of 8 bits.

A host sends serial commands to read a word, write a word, erase a word, erase or write the whole array, and open or close the programming lock. Any change to the array is followed by a simulated program cycle. Its length is set by the parameter `PROG_CYCLES`, in system clocks. During that cycle the host can poll readiness by dropping and raising select.

Top module: `serial_prom_slave`

## Requirements
- R1: A command begins at the first rising SK edge that sees CS high and DI at 1; rising edges with DI at 0 before that are skipped. Two opcode bits follow, then the address, MSB first: 6 bits when ORG is 1 and 7 bits when ORG is 0.
- R2: Opcode 10 reads. The rising edge that carries the last address bit enables DO and drives a 0 dummy bit. Each following rising SK edge presents the next word bit, MSB first. The rising edge after the last word bit releases DO.
- R3: In 16-bit mode, word a is stored as byte 2a (upper half) followed by byte 2a+1 (lower half) of the byte array, so both organisations see the same storage.
- R4: After reset, programming is locked, every array bit is 1, and DO is released.
- R5: Opcode 00 takes its meaning from the top two address bits: 11 unlocks programming, 00 locks it, 10 erases everything and 01 writes everything. The remaining address bits are clocked but ignored. Unlocking lasts until a lock command or a reset. While locked, erase, write, erase-all and write-all leave the array unchanged.
- R6: A read returns stored data whether programming is locked or unlocked.
- R7: Opcode 01 stores the 8- or 16-bit data that follows the address, MSB first, without a prior erase. Opcode 11 sets every bit of the addressed word to 1.
- R8: Write-all stores its data word in every location. Erase-all sets the whole array to 1.
- R9: If CS is dropped and raised again while a program cycle runs, DO is driven 0 while the cycle runs and 1 once it ends. The cycle lasts `PROG_CYCLES` system clocks.
- R10: If CS is raised after the program cycle has ended, DO stays released.
- R11: DO is released whenever CS is low.
- R12: A command cannot start while a program cycle runs. After a status poll, SK and DI activity is ignored until CS goes low.
- R13: Dropping CS before a command is complete abandons it and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Select pin, asynchronous to clk |
| sk_i | input | 1 | Serial shift clock pin, asynchronous to clk |
| di_i | input | 1 | Serial data input pin |
| org_i | input | 1 | Organisation: 1 selects 16-bit words, 0 selects 8-bit words; held static while CS is high |
| do_o | output | 1 | Serial data / ready-busy output value |
| do_oe_o | output | 1 | Output enable for do_o (0 means high impedance) |

## Verification
Every pin passes two synchroniser flops and one edge-detect flop before it takes effect. As a result, DO and its enable settle on the third system clock after an SK or CS change. The bench holds each SK half period for four clocks and samples only at the end of a half period.

Read bits and the dummy bit are sampled at the end of the low half that follows the rising edge which launched them. The release after the last bit is sampled at the end of the next high half.

Status is sampled six clocks after CS rises, which is well inside the program cycle, to see busy. It is sampled again `PROG_CYCLES` plus ten clocks later to see ready. Array effects are always checked by a later read, issued after the program cycle has expired.

// File: rtl/serial_prom_slave.sv
module serial_prom_slave #(
  parameter int PROG_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int BYTES = 128;
  localparam int ABITS = $clog2(BYTES);
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_STAT, S_WAIT} st_t;

  logic [2:0] cs_p, sk_p;
  logic [1:0] di_p;
  logic cs_s, cs_rise, sk_rise, di_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= '0; sk_p <= '0; di_p <= '0;
    end else begin
      cs_p <= {cs_p[1:0], cs_i};
      sk_p <= {sk_p[1:0], sk_i};
      di_p <= {di_p[0], di_i};
    end

  assign cs_s    = cs_p[1];
  assign cs_rise = cs_p[1] & ~cs_p[2];
  assign sk_rise = sk_p[1] & ~sk_p[2];
  assign di_s    = di_p[1];

  st_t st;
  logic [BYTES-1:0][7:0] mem;
  logic [15:0] sr, rsh, pw_q;
  logic [4:0] cnt, rcnt;
  logic [ABITS-1:0] adr_q, pa_q;
  logic [1:0] op_q;
  logic wen_q, go_q, all_q;
  logic [CW-1:0] bcnt;
  logic busy;

  logic [15:0] sr_nx, dat_nx, rd_nx;
  logic [4:0] bitn, hlen, tlen, dlen;
  logic [1:0] op_nx, ctl_nx;
  logic [ABITS-1:0] adr_nx;

  assign busy   = (bcnt != '0);
  assign sr_nx  = {sr[14:0], di_s};
  assign bitn   = cnt + 5'd1;
  assign hlen   = org_i ? 5'd8  : 5'd9;
  assign tlen   = org_i ? 5'd24 : 5'd17;
  assign dlen   = org_i ? 5'd16 : 5'd8;
  assign op_nx  = org_i ? sr_nx[7:6] : sr_nx[8:7];
  assign ctl_nx = org_i ? sr_nx[5:4] : sr_nx[6:5];
  assign adr_nx = org_i ? {1'b0, sr_nx[ABITS-2:0]} : sr_nx[ABITS-1:0];
  assign dat_nx = org_i ? sr_nx : {8'h00, sr_nx[7:0]};
  assign rd_nx  = org_i ? {mem[{adr_nx[ABITS-2:0], 1'b0}], mem[{adr_nx[ABITS-2:0], 1'b1}]}
                        : {mem[adr_nx], 8'h00};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sr <= '0; cnt <= '0; rsh <= '0; rcnt <= '0;
      adr_q <= '0; op_q <= '0; pa_q <= '0; pw_q <= '0;
      wen_q <= 1'b0; go_q <= 1'b0; all_q <= 1'b0;
      do_o <= 1'b0; do_oe_o <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (!cs_s) begin
        st <= S_IDLE;
        do_oe_o <= 1'b0;
      end else if (cs_rise) begin
        st <= busy ? S_STAT : S_IDLE;
        do_oe_o <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (sk_rise && di_s && !busy) begin
            st <= S_HDR; cnt <= '0; sr <= '0;
          end
          S_HDR: if (sk_rise) begin
            sr <= sr_nx; cnt <= bitn;
            if (bitn == hlen) begin
              adr_q <= adr_nx; op_q <= op_nx;
              st <= S_WAIT;
              case (op_nx)
                2'b10: begin
                  st <= S_READ; rsh <= rd_nx; rcnt <= '0;
                  do_o <= 1'b0; do_oe_o <= 1'b1;
                end
                2'b01: st <= S_DATA;
                2'b11: if (wen_q) begin
                  go_q <= 1'b1; all_q <= 1'b0; pw_q <= '1; pa_q <= adr_nx;
                end
                default: case (ctl_nx)
                  2'b11: wen_q <= 1'b1;
                  2'b00: wen_q <= 1'b0;
                  2'b10: if (wen_q) begin
                    go_q <= 1'b1; all_q <= 1'b1; pw_q <= '1;
                  end
                  default: st <= S_DATA;
                endcase
              endcase
            end
          end
          S_DATA: if (sk_rise) begin
            sr <= sr_nx; cnt <= bitn;
            if (bitn == tlen) begin
              st <= S_WAIT;
              if (wen_q) begin
                go_q <= 1'b1; all_q <= (op_q == 2'b00); pw_q <= dat_nx; pa_q <= adr_q;
              end
            end
          end
          S_READ: if (sk_rise) begin
            if (rcnt == dlen) begin
              do_oe_o <= 1'b0; st <= S_WAIT;
            end else begin
              do_o <= rsh[15]; rsh <= {rsh[14:0], 1'b0}; rcnt <= rcnt + 5'd1;
            end
          end
          S_STAT: begin
            do_oe_o <= 1'b1;
            do_o <= !busy;
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mem <= '1;
    else if (go_q)
      for (int i = 0; i < BYTES; i++)
        if (all_q || (org_i ? (i / 2 == int'(pa_q)) : (i == int'(pa_q))))
          mem[i] <= (org_i && (i % 2 == 0)) ? pw_q[15:8] : pw_q[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else if (go_q) bcnt <= CW'(PROG_CYCLES);
    else if (busy) bcnt <= bcnt - 1'b1;

  AST_HIZ_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cs_s |=> !do_oe_o); // R11
  AST_LOCK_KEEPS_ARRAY: assert property (@(posedge clk) disable iff (!rst_n) !wen_q |=> $stable(mem)); // R5
  AST_READ_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ($rose(do_oe_o) && st == S_READ) |-> !do_o); // R2
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && st == S_IDLE) |=> st != S_HDR); // R12
  AST_STAT_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n) (st == S_STAT && $past(st) == S_STAT && $past(busy) && busy) |-> (do_oe_o && !do_o)); // R9
endmodule

// File: tb/sim_serial_prom_slave.sv
module sim_serial_prom_slave;
  localparam int PROG = 50;
  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0, org = 1;
  logic dout, doe;
  int checks = 0, errors = 0;
  logic [7:0] rm [0:127];
  logic ren = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_prom_slave #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
    .do_o(dout), .do_oe_o(doe));

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int aw(); return org ? 6 : 7; endfunction
  function automatic int dw(); return org ? 16 : 8; endfunction

  function automatic logic [15:0] exp_word(int a);
    if (org) return {rm[2*a], rm[2*a+1]};
    return {8'h00, rm[a]};
  endfunction

  function automatic void m_store(int a, logic [15:0] d);
    if (org) begin rm[2*a] = d[15:8]; rm[2*a+1] = d[7:0]; end
    else rm[a] = d[7:0];
  endfunction

  task automatic pulse(logic b);
    di = b; sk = 0; w(4); sk = 1; w(4);
  endtask

  task automatic send(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic cs_on(); sk = 0; cs = 1; w(4); endtask
  task automatic cs_off(); sk = 0; cs = 0; w(6); endtask

  task automatic hdr(logic [1:0] op, logic [15:0] a);
    pulse(1'b1); send({14'd0, op}, 2); send(a, aw());
  endtask

  task automatic do_read(int a, output logic [15:0] word, input int lead = 0);
    logic dummy_ok;
    word = '0;
    cs_on();
    for (int i = 0; i < lead; i++) pulse(1'b0);
    hdr(2'b10, 16'(a));
    sk = 0; w(4);
    dummy_ok = doe && !dout;
    check("R2 dummy bit", {15'd0, dummy_ok}, 16'd1);
    for (int i = 0; i < dw(); i++) begin
      sk = 1; w(4); sk = 0; w(4);
      word = {word[14:0], dout};
    end
    sk = 1; w(4);
    check("R2 release after word", {15'd0, doe}, 16'd0);
    cs_off();
  endtask

  task automatic read_chk(string req, int a);
    logic [15:0] got;
    do_read(a, got);
    check(req, got, exp_word(a));
  endtask

  task automatic ctl(logic [1:0] code);
    cs_on(); hdr(2'b00, 16'(code) << (aw() - 2)); cs_off();
    if (code == 2'b11) ren = 1;
    if (code == 2'b00) ren = 0;
  endtask

  task automatic prog_wait(); cs_off(); w(PROG + 10); endtask

  task automatic wr(int a, logic [15:0] d);
    cs_on(); hdr(2'b01, 16'(a)); send(d, dw());
    if (ren) m_store(a, d);
  endtask

  task automatic er(int a);
    cs_on(); hdr(2'b11, 16'(a));
    if (ren) m_store(a, 16'hFFFF);
  endtask

  task automatic wral(logic [15:0] d);
    cs_on(); hdr(2'b00, 16'b01 << (aw() - 2)); send(d, dw());
    if (ren) begin
      if (org) for (int a = 0; a < 64; a++) m_store(a, d);
      else for (int a = 0; a < 128; a++) m_store(a, d);
    end
  endtask

  task automatic eral();
    cs_on(); hdr(2'b00, 16'b10 << (aw() - 2));
    if (ren) for (int i = 0; i < 128; i++) rm[i] = 8'hFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] got;
    for (int i = 0; i < 128; i++) rm[i] = 8'hFF;
    w(3); rst_n = 1; w(3);
    check("R4 DO released after reset", {15'd0, doe}, 16'd0);
    read_chk("R4 erased after reset", 0);

    // locked: write ignored, read still works
    wr(3, 16'h1234); prog_wait();
    read_chk("R5 write ignored while locked", 3);
    read_chk("R6 read while locked", 3);

    // unlock, write with status poll
    ctl(2'b11);
    wr(5, 16'hA5C3);
    cs_off();
    check("R11 DO released with CS low", {15'd0, doe}, 16'd0);
    cs = 1; w(6);
    check("R9 busy status", {14'd0, doe, dout}, 16'b10);
    w(PROG + 10);
    check("R9 ready status", {14'd0, doe, dout}, 16'b11);
    cs_off();
    read_chk("R7 write stored", 5);

    // organisation mapping
    org = 0; w(4);
    read_chk("R3 upper byte", 10);
    read_chk("R3 lower byte", 11);
    wr(11, 16'h005A); prog_wait();
    org = 1; w(4);
    read_chk("R7 overwrite without erase", 5);

    // erase one word
    er(5); prog_wait();
    read_chk("R7 erase word", 5);

    // late CS raise: no status
    wr(6, 16'h0F0F); cs_off(); w(PROG + 10);
    cs = 1; w(6);
    check("R10 no status after cycle end", {15'd0, doe}, 16'd0);
    cs_off();
    read_chk("R7 second write", 6);

    // commands during busy/status are ignored
    wr(7, 16'h1111); cs_off(); cs = 1; w(4);
    hdr(2'b01, 16'd8); send(16'h2222, 16);
    cs_off(); w(PROG);
    read_chk("R12 command in status window ignored", 8);
    read_chk("R12 prior write kept", 7);

    // abort mid-instruction
    cs_on(); hdr(2'b01, 16'd9); send(16'h00AB, 8); cs_off(); w(PROG);
    read_chk("R13 aborted write leaves word", 9);

    // lock again: erase ignored
    ctl(2'b00);
    er(7); prog_wait();
    read_chk("R5 erase ignored after lock", 7);

    // leading zeros before start bit
    do_read(7, got, 3);
    check("R1 leading zeros skipped", got, exp_word(7));

    // write-all / erase-all
    ctl(2'b11);
    wral(16'h3C96); prog_wait();
    read_chk("R8 write-all word 0", 0);
    read_chk("R8 write-all word 63", 63);
    org = 0; w(4);
    wral(16'h0077); prog_wait();
    read_chk("R8 write-all x8 byte 100", 100);
    eral(); prog_wait();
    read_chk("R8 erase-all byte 1", 1);
    org = 1; w(4);
    read_chk("R8 erase-all word 40", 40);

    // random mix, fixed seed
    void'($urandom(32'h5EED));
    for (int it = 0; it < 40; it++) begin
      int op, a;
      logic [15:0] d;
      org = 1'($urandom % 2); w(4);
      a = int'($urandom % (org ? 64 : 128));
      d = 16'($urandom);
      if (!org) d[15:8] = 8'h00;
      op = int'($urandom % 8);
      case (op)
        0, 1, 2: read_chk("R1 random read", a);
        3, 4: begin wr(a, d); prog_wait(); end
        5: begin er(a); prog_wait(); end
        6: ctl(($urandom % 2) ? 2'b11 : 2'b00);
        default: if ($urandom % 4 == 0) begin wral(d); prog_wait(); end
                 else read_chk("R6 random read", a);
      endcase
    end
    for (int a = 0; a < 64; a++) if (a % 9 == 0) read_chk("R7 final sweep", a);
    summary();
  end
endmodule